// File: doc/BRIEF.md
# Fractional Clock-Enable Generator with Half-Step Pre-Divider

This block turns a fast reference clock into a stream of single-cycle enable pulses plus a companion level signal. The pulse rate is set in two stages. A pre-divider counts in half steps, so the divide ratio can be 1, 1.5, 2, 2.5 and so on. An optional fractional accumulator then keeps M of every N pre-divided pulses. The level output either toggles on each pulse or, in fractional mode, follows a programmable duty threshold.

Configuration comes straight from a register block in its stored form. The N field holds the bitwise complement of (N - M). The duty field holds the complement of the duty threshold. The block decodes both encodings itself. A new configuration takes effect only at a frame boundary, so a change never cuts an output period short. Both outputs are plain strobes with no back-pressure: a consumer must take every pulse in the cycle it appears.

Top module: `mnd_clk_gen`

## Requirements
- R1: With pre-divider code h >= 1 and fractional mode off, exactly 2 pulses appear per h+1 enabled input cycles, with the remainder carried from cycle to cycle. Code 0 gives one pulse every enabled cycle.
- R2: When `frac_en` is 0, the values on `m_val`, `n_inv` and `d_inv` have no effect on `pulse_o` or `level_o`.
- R3: In fractional mode, the effective N is ((~n_inv) + m_val) mod 2^MND_W. Exactly m_val output pulses appear for every N pre-divided pulses.
- R4: In fractional mode the counter value after each update is the residue. `level_o` is high in the following cycle exactly when this residue is below the duty threshold ~d_inv.
- R5: When the effective N equals M, every pre-divided pulse is passed to `pulse_o`, and `level_o` toggles on each pulse (50% duty).
- R6: In fractional mode, an M of 0, an effective N of 0, or an effective N below M holds both outputs low.
- R7: While `en` is low, both outputs are low on the next cycle and all counters clear. The configuration inputs are taken over directly, so the next enabled cycle starts a fresh frame. After reset, both outputs are low.
- R8: While enabled, a changed configuration is taken over only at a frame boundary. A frame boundary is a pre-divided pulse after which both the pre-divider remainder and the fractional residue are zero.
- R9: Outputs are registered. A pulse decided from the inputs sampled at one clock edge appears at `pulse_o` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low clears counters and loads configuration |
| pre_code | input | PRE_W | Half-step pre-divider code h (ratio (h+1)/2, 0 = none) |
| frac_en | input | 1 | Fractional M/N mode select |
| m_val | input | MND_W | Numerator M |
| n_inv | input | MND_W | Complement of (N - M) |
| d_inv | input | MND_W | Complement of the duty threshold |
| pulse_o | output | 1 | Single-cycle output enable pulse |
| level_o | output | 1 | Toggle or duty-shaped level |

## Verification
The assertions rely on three things. `en` and `rst_n` are synchronous to `clk`. Configuration may change in any cycle, because the block freezes its own copy. The residue bound applies only while the frozen class is fractional, since decoding guarantees N > M >= 1 there. The bench changes configuration on the falling edge, both during idle and in the middle of a frame. It covers every class: plain divide, pass-through, fractional, and each degenerate case. A cycle-accurate scoreboard checks every output sample.

// File: rtl/mnd_clk_pkg.sv
package mnd_clk_pkg;
  typedef enum logic [1:0] {
    CLS_DIVIDE = 2'd0,
    CLS_PASS   = 2'd1,
    CLS_FRAC   = 2'd2,
    CLS_HOLD   = 2'd3
  } op_class_e;
endpackage

// File: rtl/mnd_cfg_decode.sv
module mnd_cfg_decode
  import mnd_clk_pkg::*;
#(
  parameter int PW = 5,
  parameter int MW = 8
) (
  input  logic [PW-1:0] pre_code,
  input  logic          frac_en,
  input  logic [MW-1:0] m_val,
  input  logic [MW-1:0] n_inv,
  input  logic [MW-1:0] d_inv,
  output logic [PW:0]   lim,
  output op_class_e     cls,
  output logic [MW-1:0] n_eff,
  output logic [MW-1:0] duty
);
  localparam logic [PW:0] LIM_MIN = (PW+1)'(2);
  localparam logic [PW:0] ONE_W   = (PW+1)'(1);

  always_comb begin
    // half-step limit: accumulator gains 2 per cycle, fires at h+1
    lim   = (pre_code == '0) ? LIM_MIN : ({1'b0, pre_code} + ONE_W);
    n_eff = (~n_inv) + m_val;
    duty  = ~d_inv;
    if (!frac_en)
      cls = CLS_DIVIDE;
    else if (m_val == '0 || n_eff == '0 || n_eff < m_val)
      cls = CLS_HOLD;
    else if (n_eff == m_val)
      cls = CLS_PASS;
    else
      cls = CLS_FRAC;
  end
endmodule

// File: rtl/half_step_prediv.sv
module half_step_prediv #(
  parameter int PW = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [PW:0] lim,
  output logic        fire,
  output logic        wrap
);
  localparam int AW = PW + 2;

  logic [AW-1:0] acc_q, acc_d, sum, lim_w;

  always_comb begin
    lim_w = AW'(lim);
    sum   = acc_q + AW'(2);
    fire  = run && (sum >= lim_w);
    wrap  = fire && (sum == lim_w);
    if (!run)
      acc_d = '0;
    else if (fire)
      acc_d = sum - lim_w;
    else
      acc_d = sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // remainder never reaches the active limit
  assert_acc_below_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (acc_q < lim_w));
endmodule

// File: rtl/mnd_accum.sv
module mnd_accum
  import mnd_clk_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  op_class_e     cls,
  input  logic [MW-1:0] m_val,
  input  logic [MW-1:0] n_eff,
  input  logic [MW-1:0] duty,
  output logic          fire,
  output logic          at_zero,
  output logic          high
);
  logic [MW-1:0] cnt_q, cnt_d;
  logic [MW:0]   t_sum, n_w;

  always_comb begin
    t_sum = {1'b0, cnt_q} + {1'b0, m_val};
    n_w   = {1'b0, n_eff};
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else begin
      case (cls)
        CLS_DIVIDE, CLS_PASS: begin
          fire  = step;
          cnt_d = '0;
        end
        CLS_HOLD: cnt_d = '0;
        default: begin
          if (step) begin
            if (t_sum >= n_w) begin
              fire  = 1'b1;
              cnt_d = MW'(t_sum - n_w);
            end else begin
              cnt_d = t_sum[MW-1:0];
            end
          end
        end
      endcase
    end
    at_zero = (cnt_d == '0);
    high    = (cnt_d < duty);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // residue stays below effective N in fractional operation
  assert_residue_below_n_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cls == CLS_FRAC) |-> (cnt_q < n_eff));
endmodule

// File: rtl/mnd_clk_gen.sv
module mnd_clk_gen
  import mnd_clk_pkg::*;
#(
  parameter int PRE_W = 5,
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] pre_code,
  input  logic             frac_en,
  input  logic [MND_W-1:0] m_val,
  input  logic [MND_W-1:0] n_inv,
  input  logic [MND_W-1:0] d_inv,
  output logic             pulse_o,
  output logic             level_o
);
  localparam logic [PRE_W:0] LIM_RST = (PRE_W+1)'(2);

  logic [PRE_W:0]   dec_lim, sh_lim;
  op_class_e        dec_cls, sh_cls;
  logic [MND_W-1:0] dec_n, dec_duty, sh_m, sh_n, sh_d;
  logic             pre_fire, pre_wrap, mnd_fire, mnd_zero, mnd_high, load;

  mnd_cfg_decode #(.PW(PRE_W), .MW(MND_W)) u_dec (
    .pre_code(pre_code), .frac_en(frac_en), .m_val(m_val), .n_inv(n_inv),
    .d_inv(d_inv), .lim(dec_lim), .cls(dec_cls), .n_eff(dec_n), .duty(dec_duty)
  );

  half_step_prediv #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(en), .lim(sh_lim),
    .fire(pre_fire), .wrap(pre_wrap)
  );

  mnd_accum #(.MW(MND_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(en), .step(pre_fire), .cls(sh_cls),
    .m_val(sh_m), .n_eff(sh_n), .duty(sh_d),
    .fire(mnd_fire), .at_zero(mnd_zero), .high(mnd_high)
  );

  // frame boundary: both remainders return to zero together
  assign load = !en || (pre_wrap && mnd_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_lim <= LIM_RST;
      sh_cls <= CLS_DIVIDE;
      sh_m   <= '0;
      sh_n   <= '0;
      sh_d   <= '0;
    end else if (load) begin
      sh_lim <= dec_lim;
      sh_cls <= dec_cls;
      sh_m   <= m_val;
      sh_n   <= dec_n;
      sh_d   <= dec_duty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      pulse_o <= 1'b0;
      level_o <= 1'b0;
    end else begin
      pulse_o <= mnd_fire;
      case (sh_cls)
        CLS_FRAC: level_o <= mnd_high;
        CLS_HOLD: level_o <= 1'b0;
        default:  level_o <= level_o ^ mnd_fire;
      endcase
    end
  end

  assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sh_cls == CLS_HOLD) |=> (!pulse_o && !level_o));

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pulse_o && !level_o));

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(pre_wrap && mnd_zero)) |=> ($stable(sh_lim) && $stable(sh_m) && $stable(sh_n)));

  assert_pass_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (sh_cls == CLS_PASS || sh_cls == CLS_DIVIDE)) |=> (pulse_o == $past(pre_fire)));
endmodule

// File: tb/mnd_clk_gen_test.sv
`timescale 1ns/1ps
module mnd_clk_gen_test;
  localparam int PW = 5;
  localparam int MW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [PW-1:0] pre_code = '0;
  logic frac_en = 1'b0;
  logic [MW-1:0] m_val = '0, n_inv = '0, d_inv = '0;
  logic pulse_o, level_o;

  int tests = 0, fails = 0;
  int obs_pulses = 0, obs_high = 0;
  string cur_tag = "R7";
  bit done = 1'b0;
  logic [1:0] exp_q[$];

  // reference model state
  int r_acc = 0, r_cnt = 0, s_lim = 2, s_cls = 0, s_m = 0, s_n = 0, s_d = 0;
  bit e_pulse = 0, e_level = 0;

  always #2.5 clk = ~clk;

  mnd_clk_gen #(.PRE_W(PW), .MND_W(MW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .pre_code(pre_code), .frac_en(frac_en),
    .m_val(m_val), .n_inv(n_inv), .d_inv(d_inv), .pulse_o(pulse_o), .level_o(level_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_cfg();
    int n;
    n = ((255 - int'(n_inv)) + int'(m_val)) % 256;
    s_lim = (pre_code == 0) ? 2 : int'(pre_code) + 1;
    s_m = int'(m_val);
    s_n = n;
    s_d = 255 - int'(d_inv);
    if (!frac_en) s_cls = 0;
    else if (s_m == 0 || n == 0 || n < s_m) s_cls = 3;
    else if (n == s_m) s_cls = 1;
    else s_cls = 2;
  endtask

  task automatic model_step();
    int sum, t;
    bit pf, fire;
    if (!en) begin
      r_acc = 0; r_cnt = 0; e_pulse = 0; e_level = 0;
      load_cfg();
    end else begin
      sum = r_acc + 2;
      pf = (sum >= s_lim);
      r_acc = pf ? sum - s_lim : sum;
      fire = 0;
      case (s_cls)
        0, 1: begin fire = pf; r_cnt = 0; end
        3: r_cnt = 0;
        default: if (pf) begin
          t = r_cnt + s_m;
          if (t >= s_n) begin fire = 1; r_cnt = t - s_n; end
          else r_cnt = t;
        end
      endcase
      if (s_cls == 2) e_level = (r_cnt < s_d);
      else if (s_cls == 3) e_level = 0;
      else e_level = e_level ^ fire;
      e_pulse = fire;
      if (pf && r_acc == 0 && r_cnt == 0) load_cfg();
    end
  endtask

  task automatic drive(input bit e, input int pc, input bit fe, input int m,
                       input int ni, input int di, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      en = e; pre_code = PW'(pc); frac_en = fe;
      m_val = MW'(m); n_inv = MW'(ni); d_inv = MW'(di);
      model_step();
      exp_q.push_back({e_pulse, e_level});
    end
  endtask

  // idle cycle, k enabled cycles, idle cycle; then compare pulse/high counts
  task automatic run_case(input string tag, input int pc, input bit fe, input int m,
                          input int ni, input int di, input int k,
                          input int exp_p, input int exp_h);
    cur_tag = tag;
    drive(0, pc, fe, m, ni, di, 1);
    obs_pulses = 0; obs_high = 0;
    drive(1, pc, fe, m, ni, di, k);
    drive(0, pc, fe, m, ni, di, 1);
    @(negedge clk);
    check({tag, " pulse count"}, obs_pulses, exp_p);
    if (exp_h >= 0) check({tag, " level-high count"}, obs_high, exp_h);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      e = exp_q.pop_front();
      check({cur_tag, " scoreboard pulse"}, int'(pulse_o), int'(e[1]));
      check({cur_tag, " scoreboard level"}, int'(level_o), int'(e[0]));
      if (pulse_o) obs_pulses++;
      if (level_o) obs_high++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired (tag %s)", cur_tag);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset pulse", int'(pulse_o), 0);
    check("R7 reset level", int'(level_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    run_case("R1 code0", 0, 0, 0, 0, 0, 20, 20, -1);
    run_case("R1 code2", 2, 0, 0, 0, 0, 30, 20, -1);
    run_case("R1 code5", 5, 0, 0, 0, 0, 30, 10, -1);
    run_case("R2 junk fields", 3, 0, 77, 3, 9, 30, 15, -1);
    run_case("R2 clean fields", 3, 0, 0, 0, 0, 30, 15, -1);
    run_case("R3 R4 m3 n8", 0, 1, 3, 250, 251, 80, 30, 40);
    run_case("R3 m1 n3 code2", 2, 1, 1, 253, 254, 90, 20, -1);
    run_case("R5 pass", 0, 1, 5, 255, 0, 20, 20, 10);
    run_case("R6 overflow", 0, 1, 200, 155, 0, 30, 0, 0);
    run_case("R6 m zero", 0, 1, 0, 250, 0, 30, 0, 0);
    run_case("R6 n zero", 0, 1, 4, 3, 0, 30, 0, 0);

    // R8: change mid-frame; takes effect only after residue wraps
    cur_tag = "R8";
    drive(0, 0, 1, 1, 252, 253, 1);
    obs_pulses = 0; obs_high = 0;
    drive(1, 0, 1, 1, 252, 253, 2);
    drive(1, 0, 0, 0, 0, 0, 6);
    drive(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    check("R8 deferred reload pulses", obs_pulses, 5);

    // R7: enable drop mid-frame clears the state
    cur_tag = "R7";
    drive(1, 0, 1, 3, 250, 251, 5);
    drive(0, 0, 1, 3, 250, 251, 1);
    obs_pulses = 0; obs_high = 0;
    drive(1, 0, 1, 3, 250, 251, 8);
    drive(0, 0, 1, 3, 250, 251, 1);
    @(negedge clk);
    check("R7 restart pulses", obs_pulses, 3);

    // R9: first pulse visible right after the first enabled edge
    cur_tag = "R9";
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(1, 0, 0, 0, 0, 0, 1);
    @(posedge clk); #1.5;
    check("R9 pulse after first edge", int'(pulse_o), 1);
    drive(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule